// File: doc/BRIEF.md
# SMI Source Status Controller

This block collects system management interrupt requests from fifteen sources and turns them into one active-low request line toward the processor. Seven sources land in the first status register and eight in the second: timer expiries, wake-up events, an I/O restart request, a halt cycle, a processor restart request, a pair of external pins folded into one source, a software trigger and six auxiliary inputs. Each source has a sticky status bit that latches on a rising edge of the source and stays set until software clears it by writing a one to it.

Two enable registers mask the status bits, and the top bit of the first enable register is a global gate on the output. Software reaches all registers through an index/data pair: a write on the index strobe selects a register, and data writes and reads then act on the selected register. The top bit of the first status register reports whether anything is pending in the second one, so a handler can poll one register first.

Top module: `smi_status_ctrl`

## Requirements
- R1: A hardware source sets its status bit at the first clock edge at which it is sampled high after being sampled low; a source held high does not set the bit again. Mapping: status A bit i = `evt_a_i[i]` (i = 0..6); status B bit 0 = `ext_pin_i[0] | ext_pin_i[1]`; status B bits 7..2 = `aux_i[5:0]`. Bits latch whatever the state of the output.
- R2: Bit 7 of status A (index 0x90) reads 1 exactly when any bit of status B (index 0x91) is set; it has no storage of its own.
- R3: Sources that rise in the same cycle all set their bits in that cycle.
- R4: A status bit stays set until a data write with a 1 in its position; writing 0 leaves it unchanged, and writing bit 7 of status A has no effect.
- R5: When a source rises in the same cycle as a write-1 clear of its bit, the bit ends up set.
- R6: Enable A (index 0x92) and enable B (index 0x93) are written and read back through the data port; bits 6..0 of enable A and all of enable B mask the status bits of the same position, bit 7 of enable A is the global enable.
- R7: `smi_n_o` is low exactly when the global enable is set and at least one status bit is set together with its enable bit; it follows the register state of the same clock edge.
- R8: Clearing the global enable forces `smi_n_o` high in the following cycle, so setting it again produces a fresh falling edge.
- R9: Whenever index 0x90 reads 0x00, `smi_n_o` is high.
- R10: A data write to index 0x94 with bit 0 set sets status B bit 1 (software request); with bit 0 clear it has no effect.
- R11: `idx_wr_i` loads `wdata_i` into the index register; an index other than 0x90..0x93 reads 0x00 and data writes to it change no register (0x94 excepted as in R10).
- R12: Reset clears all status and enable bits and the index, and leaves `smi_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idx_wr_i | input | 1 | Load `wdata_i` into the index register |
| dat_wr_i | input | 1 | Write `wdata_i` to the selected register |
| wdata_i | input | 8 | Write data for index and data strobes |
| rdata_o | output | 8 | Contents of the selected register |
| evt_a_i | input | 7 | Sources for status A bits 6..0 |
| ext_pin_i | input | 2 | External request pins, ORed into one source |
| aux_i | input | 6 | Sources for status B bits 7..2 |
| smi_n_o | output | 1 | Active-low interrupt request |

## Verification
The functions that can collide are the set path from a rising source and the write-1 clear from the data port, both acting on the same status bit at the same edge. The bench provokes this by raising a source at the negative edge where it also drives a data write with a one in that bit's position, so both are sampled at one rising edge. The bit is then read back through the index port and must be set, and a second clear alone must then empty it.

// File: rtl/smi_pkg.sv
package smi_pkg;

    localparam int REG_W    = 8;
    localparam int A_SRC_W  = REG_W - 1;
    localparam int B_AUX_W  = REG_W - 2;
    localparam int SRC_W    = A_SRC_W + 1 + B_AUX_W;

    localparam logic [REG_W-1:0] IDX_STAT_A = 8'h90;
    localparam logic [REG_W-1:0] IDX_STAT_B = 8'h91;
    localparam logic [REG_W-1:0] IDX_EN_A   = 8'h92;
    localparam logic [REG_W-1:0] IDX_EN_B   = 8'h93;
    localparam logic [REG_W-1:0] IDX_SWTRIG = 8'h94;

    typedef struct packed {
        logic [REG_W-1:0]   idx;
        logic [A_SRC_W-1:0] stat_a;
        logic [REG_W-1:0]   stat_b;
        logic [REG_W-1:0]   en_a;
        logic [REG_W-1:0]   en_b;
        logic               smi_n;
    } smi_regs_t;

endpackage

// File: rtl/smi_edge_det.sv
module smi_edge_det #(
    parameter int N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] src_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = src_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise_o[i] = src_i[i] & ~prev_q[i];
    end

endmodule

// File: rtl/smi_regfile.sv
module smi_regfile
    import smi_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               idx_wr_i,
    input  logic               dat_wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic [A_SRC_W-1:0] set_a_i,
    input  logic               set_ext_i,
    input  logic [B_AUX_W-1:0] set_aux_i,
    output smi_regs_t          regs_o
);

    smi_regs_t          r_d, r_q;
    logic [A_SRC_W-1:0] clr_a;
    logic [REG_W-1:0]   clr_b;
    logic [REG_W-1:0]   set_b;
    logic               sw_set;
    logic               pend;

    always_comb begin
        r_d    = r_q;
        clr_a  = '0;
        clr_b  = '0;
        sw_set = 1'b0;

        if (dat_wr_i) begin
            unique case (r_q.idx)
                IDX_STAT_A: clr_a = wdata_i[A_SRC_W-1:0];
                IDX_STAT_B: clr_b = wdata_i;
                IDX_EN_A:   r_d.en_a = wdata_i;
                IDX_EN_B:   r_d.en_b = wdata_i;
                IDX_SWTRIG: sw_set = wdata_i[0];
                default:    ;
            endcase
        end

        if (idx_wr_i) r_d.idx = wdata_i;

        set_b = {set_aux_i, sw_set, set_ext_i};

        // set dominates clear in the same cycle
        r_d.stat_a = (r_q.stat_a & ~clr_a) | set_a_i;
        r_d.stat_b = (r_q.stat_b & ~clr_b) | set_b;

        pend = (|(r_d.stat_a & r_d.en_a[A_SRC_W-1:0])) | (|(r_d.stat_b & r_d.en_b));
        r_d.smi_n = ~(r_d.en_a[REG_W-1] & pend);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q       <= '0;
            r_q.smi_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign regs_o = r_q;

endmodule

// File: rtl/smi_rd_mux.sv
module smi_rd_mux
    import smi_pkg::*;
(
    input  smi_regs_t        regs_i,
    output logic [REG_W-1:0] rdata_o
);

    always_comb begin
        unique case (regs_i.idx)
            IDX_STAT_A: rdata_o = {|regs_i.stat_b, regs_i.stat_a};
            IDX_STAT_B: rdata_o = regs_i.stat_b;
            IDX_EN_A:   rdata_o = regs_i.en_a;
            IDX_EN_B:   rdata_o = regs_i.en_b;
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/smi_status_ctrl.sv
module smi_status_ctrl
    import smi_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               idx_wr_i,
    input  logic               dat_wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [REG_W-1:0]   rdata_o,
    input  logic [A_SRC_W-1:0] evt_a_i,
    input  logic [1:0]         ext_pin_i,
    input  logic [B_AUX_W-1:0] aux_i,
    output logic               smi_n_o
);

    logic [SRC_W-1:0]   rise;
    smi_regs_t          regs;
    logic [REG_W-1:0]   idx_q;
    logic [A_SRC_W-1:0] stat_a_q;
    logic [REG_W-1:0]   stat_b_q;
    logic [REG_W-1:0]   en_a_q;

    smi_edge_det #(.N(SRC_W)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  ({aux_i, |ext_pin_i, evt_a_i}),
        .rise_o (rise)
    );

    smi_regfile u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .idx_wr_i  (idx_wr_i),
        .dat_wr_i  (dat_wr_i),
        .wdata_i   (wdata_i),
        .set_a_i   (rise[A_SRC_W-1:0]),
        .set_ext_i (rise[A_SRC_W]),
        .set_aux_i (rise[SRC_W-1:A_SRC_W+1]),
        .regs_o    (regs)
    );

    smi_rd_mux u_rd (
        .regs_i  (regs),
        .rdata_o (rdata_o)
    );

    assign smi_n_o  = regs.smi_n;
    assign idx_q    = regs.idx;
    assign stat_a_q = regs.stat_a;
    assign stat_b_q = regs.stat_b;
    assign en_a_q   = regs.en_a;

endmodule

// File: rtl/smi_status_chk.sv
module smi_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dat_wr,
    input logic [7:0] idx,
    input logic [7:0] rdata,
    input logic [1:0] ext_pin,
    input logic [6:0] stat_a,
    input logic [7:0] stat_b,
    input logic [7:0] en_a,
    input logic       smi_n
);

    assert_ext_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|ext_pin) |=> stat_b[0]);

    assert_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == 8'h90) |-> (rdata[7] == (stat_b != 8'h00)));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dat_wr) |-> ((($past(stat_b) & ~stat_b) == 8'h00) &&
                            (($past(stat_a) & ~stat_a) == 7'h00)));

    assert_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_n |-> en_a[7]);

    assert_toggle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_a[7]) |-> smi_n);

    assert_zero_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (idx == 8'h90 && rdata == 8'h00) |-> smi_n);

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (idx < 8'h90 || idx > 8'h93) |-> (rdata == 8'h00));

endmodule

bind smi_status_ctrl smi_status_chk u_chk (
    .clk     (clk_i),
    .rst_n   (rst_ni),
    .dat_wr  (dat_wr_i),
    .idx     (idx_q),
    .rdata   (rdata_o),
    .ext_pin (ext_pin_i),
    .stat_a  (stat_a_q),
    .stat_b  (stat_b_q),
    .en_a    (en_a_q),
    .smi_n   (smi_n_o)
);

// File: tb/smi_status_ctrl_tb.sv
module smi_status_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_wr = 1'b0;
    logic       dat_wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [6:0] evt_a = '0;
    logic [1:0] ext_pin = '0;
    logic [5:0] aux = '0;
    logic       smi_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    smi_status_ctrl u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .idx_wr_i  (idx_wr),
        .dat_wr_i  (dat_wr),
        .wdata_i   (wdata),
        .rdata_o   (rdata),
        .evt_a_i   (evt_a),
        .ext_pin_i (ext_pin),
        .aux_i     (aux),
        .smi_n_o   (smi_n)
    );

    // {evt_a 7, ext 2, aux 6, status A 8, status B 8, smi_n 1}
    localparam logic [31:0] VEC [7] = '{
        {7'h01, 2'b00, 6'h00, 8'h01, 8'h00, 1'b0},
        {7'h40, 2'b00, 6'h00, 8'h40, 8'h00, 1'b0},
        {7'h00, 2'b01, 6'h00, 8'h80, 8'h01, 1'b0},
        {7'h00, 2'b10, 6'h00, 8'h80, 8'h01, 1'b0},
        {7'h00, 2'b11, 6'h20, 8'h80, 8'h81, 1'b0},
        {7'h2A, 2'b00, 6'h01, 8'hAA, 8'h04, 1'b0},
        {7'h00, 2'b00, 6'h00, 8'h00, 8'h00, 1'b1}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic put_idx(input logic [7:0] a);
        @(negedge clk); idx_wr = 1'b1; wdata = a;
        @(negedge clk); idx_wr = 1'b0;
    endtask

    task automatic put_dat(input logic [7:0] d);
        @(negedge clk); dat_wr = 1'b1; wdata = d;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
        put_idx(a);
        put_dat(d);
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
        put_idx(a);
        d = rdata;
    endtask

    task automatic clear_all();
        wr_reg(8'h90, 8'hFF);
        wr_reg(8'h91, 8'hFF);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        check("R12 smi_n", {7'h0, smi_n}, 8'h01);
        rd_reg(8'h90, v); check("R12 stat A", v, 8'h00);
        rd_reg(8'h91, v); check("R12 stat B", v, 8'h00);
        rd_reg(8'h92, v); check("R12 en A", v, 8'h00);
        rd_reg(8'h93, v); check("R12 en B", v, 8'h00);

        // R6 enables readback
        wr_reg(8'h92, 8'hFF); rd_reg(8'h92, v); check("R6 en A", v, 8'hFF);
        wr_reg(8'h93, 8'hFF); rd_reg(8'h93, v); check("R6 en B", v, 8'hFF);

        // table: R1 R2 R3 R7
        foreach (VEC[i]) begin
            @(negedge clk);
            evt_a = VEC[i][31:25]; ext_pin = VEC[i][24:23]; aux = VEC[i][22:17];
            @(negedge clk);
            evt_a = '0; ext_pin = '0; aux = '0;
            check("R7 smi_n vec", {7'h0, smi_n}, {7'h0, VEC[i][0]});
            rd_reg(8'h90, v); check("R1/R2/R3 stat A vec", v, VEC[i][16:9]);
            rd_reg(8'h91, v); check("R1/R3 stat B vec", v, VEC[i][8:1]);
            clear_all();
            check("R4 smi_n after clear", {7'h0, smi_n}, 8'h01);
        end

        // R1: held source does not re-latch after clear
        @(negedge clk); evt_a = 7'h01;
        @(negedge clk);
        wr_reg(8'h90, 8'h01);
        rd_reg(8'h90, v); check("R1 held source", v, 8'h00);
        evt_a = '0;

        // R4: zero write and write to summary bit do nothing
        @(negedge clk); aux = 6'h01; evt_a = 7'h08;
        @(negedge clk); aux = '0; evt_a = '0;
        wr_reg(8'h90, 8'h80);
        rd_reg(8'h90, v); check("R4 summary write", v, 8'h88);
        wr_reg(8'h91, 8'h00);
        rd_reg(8'h91, v); check("R4 zero write", v, 8'h04);

        // R8: global enable toggle
        check("R8 low before", {7'h0, smi_n}, 8'h00);
        wr_reg(8'h92, 8'h7F);
        check("R8 high after clear gen", {7'h0, smi_n}, 8'h01);
        wr_reg(8'h92, 8'hFF);
        check("R8 low after set gen", {7'h0, smi_n}, 8'h00);

        // R7: masked bits keep line high
        wr_reg(8'h92, 8'h80); wr_reg(8'h93, 8'h00);
        check("R7 masked", {7'h0, smi_n}, 8'h01);
        wr_reg(8'h93, 8'h04);
        check("R7 unmasked B2", {7'h0, smi_n}, 8'h00);
        wr_reg(8'h92, 8'hFF); wr_reg(8'h93, 8'hFF);
        clear_all();

        // R9: idle reads zero and line high
        rd_reg(8'h90, v); check("R9 stat A idle", v, 8'h00);
        check("R9 smi_n idle", {7'h0, smi_n}, 8'h01);

        // R10 software request
        wr_reg(8'h94, 8'hFE);
        rd_reg(8'h91, v); check("R10 bit0 clear", v, 8'h00);
        wr_reg(8'h94, 8'h01);
        rd_reg(8'h91, v); check("R10 sw set", v, 8'h02);
        clear_all();

        // R11 unmapped index
        wr_reg(8'h50, 8'hFF);
        check("R11 unmapped read", rdata, 8'h00);
        rd_reg(8'h92, v); check("R11 en A intact", v, 8'hFF);
        rd_reg(8'h91, v); check("R11 stat B intact", v, 8'h00);

        // R5 set wins over clear in the same cycle
        put_idx(8'h90);
        @(negedge clk); evt_a = 7'h04; dat_wr = 1'b1; wdata = 8'h04;
        @(negedge clk); evt_a = '0; dat_wr = 1'b0;
        check("R5 collision", rdata, 8'h04);
        put_dat(8'h04);
        check("R5 later clear", rdata, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule